// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a 32-bit virtual address into a physical address after a translation lookaside buffer miss. It reads page-table descriptors through a single read port. The first read goes to a 4096-entry top-level table, indexed by the upper twelve address bits, and the block decodes the word that comes back. A section or supersection entry ends the walk at that point. A table-pointer entry leads to a second read from a 256-entry lower-level table, which resolves a 64 KB or 4 KB page. Any entry the block cannot use ends the walk with a translation fault.

The result is a physical address, a two-bit page-size code and a fault flag. All three are valid during a one-cycle completion pulse, and the fill logic of a translation buffer can capture them at that point. The block handles one walk at a time. A walk request is accepted through a valid/ready pair, and the ready output stays low until the walk has completed. The memory request side also uses valid/ready. Once the walker raises `mem_req_valid`, it holds the request with a stable address until the memory accepts it. The memory may return the descriptor any number of cycles later, with a one-cycle `mem_rsp_valid`, and the walker cannot stall that response.

Top module: `tlb_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `mem_req_valid` and `walk_done` are 0.
- R2: The first read of a walk targets `table_base` with bits [13:0] replaced by VA[31:20] shifted left by two. The low 14 bits of `table_base` have no effect.
- R3: A top-level descriptor whose bits [1:0] are 00 or 11 ends the walk after one read. The walk then completes with `walk_fault`=1, `walk_pa`=0 and `walk_size`=0.
- R4: Type 10 with bit 18 clear is a 1 MB section. The walk completes after one read with PA = {desc[31:20], VA[19:0]} and `walk_size`=0.
- R5: Type 10 with bit 18 set is a 16 MB supersection. The walk completes after one read with PA = {desc[31:24], VA[23:0]} and `walk_size`=3.
- R6: Type 01 starts a second read at the descriptor with bits [9:0] replaced by VA[19:12] shifted left by two. The low 10 descriptor bits have no effect on that address.
- R7: A lower-level descriptor of type 01 is a 64 KB page, with PA = {desc[31:16], VA[15:0]} and `walk_size`=1.
- R8: A lower-level descriptor of type 10 is a 4 KB page, with PA = {desc[31:12], VA[11:0]} and `walk_size`=2.
- R9: A lower-level descriptor of type 00 or 11 ends the walk as a fault, with PA 0 and size 0, after exactly two reads.
- R10: `req_ready` is low from the cycle after a request is accepted until the walk completes. `walk_done` is high for exactly one cycle per walk.
- R11: While `mem_req_ready` is low, `mem_req_valid` stays high and `mem_addr` does not change. A response arriving after any number of idle cycles is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 32 | Virtual address to translate |
| table_base | input | 32 | Top-level table base (bits [13:0] ignored) |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read this cycle |
| mem_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor word returned this cycle |
| mem_rsp_data | input | 32 | Returned descriptor word |
| walk_done | output | 1 | One-cycle completion pulse |
| walk_fault | output | 1 | Translation fault, valid with `walk_done` |
| walk_size | output | 2 | 0 section, 1 64 KB, 2 4 KB, 3 supersection |
| walk_pa | output | 32 | Translated physical address |

## Verification
Some properties are checked on every cycle. These are:
- the single-cycle completion pulse;
- the busy-low ready;
- the stable held read request;
- the zeroed result on a fault;
- the exact address of both reads, which the checker rebuilds from the captured VA and the first returned word;
- the read count, one for section and supersection results and two for page results.

The bench scenarios show the rest. These are the physical address composed for each page size, the decoding of every descriptor type at both levels, and the fact that the low base and pointer bits are ignored. The scenarios are run against random memory stalls and response delays.

// File: rtl/tlb_walker_pkg.sv
`timescale 1ns/1ps
package tlb_walker_pkg;
  typedef enum logic [1:0] {
    PG_SECTION = 2'd0,
    PG_LARGE   = 2'd1,
    PG_SMALL   = 2'd2,
    PG_SUPER   = 2'd3
  } pg_size_e;

  typedef enum logic [1:0] {
    TOP_FAULT   = 2'd0,
    TOP_TABLE   = 2'd1,
    TOP_SECTION = 2'd2,
    TOP_RSVD    = 2'd3
  } top_type_e;

  typedef enum logic [1:0] {
    LOW_FAULT = 2'd0,
    LOW_LARGE = 2'd1,
    LOW_SMALL = 2'd2,
    LOW_RSVD  = 2'd3
  } low_type_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TOP_REQ,
    ST_TOP_WAIT,
    ST_LOW_REQ,
    ST_LOW_WAIT,
    ST_DONE
  } walk_st_e;
endpackage

// File: rtl/tw_fetch_addr.sv
`timescale 1ns/1ps
module tw_fetch_addr #(
  parameter int VA_W         = 32,
  parameter int TOP_TBL_SH   = 14,
  parameter int LOW_TBL_SH   = 10,
  parameter int SECT_SH      = 20,
  parameter int PAGE_SH      = 12
) (
  input  logic [VA_W-1:0] table_base,
  input  logic [VA_W-1:0] ptr_desc,
  input  logic [VA_W-1:0] va,
  output logic [VA_W-1:0] top_addr,
  output logic [VA_W-1:0] low_addr
);
  localparam logic [VA_W-1:0] TOP_MASK = ~((VA_W'(1) << TOP_TBL_SH) - VA_W'(1));
  localparam logic [VA_W-1:0] LOW_MASK = ~((VA_W'(1) << LOW_TBL_SH) - VA_W'(1));

  logic [VA_W-1:0] top_idx, low_idx;

  always_comb begin
    top_idx  = VA_W'(va[VA_W-1:SECT_SH]) << 2;
    low_idx  = VA_W'(va[SECT_SH-1:PAGE_SH]) << 2;
    top_addr = (table_base & TOP_MASK) | top_idx;
    low_addr = (ptr_desc & LOW_MASK) | low_idx;
  end
endmodule

// File: rtl/tw_top_decode.sv
`timescale 1ns/1ps
module tw_top_decode
  import tlb_walker_pkg::*;
(
  input  logic [1:0] type_bits,
  input  logic       super_flag,
  output logic       fault,
  output logic       descend,
  output pg_size_e   size
);
  always_comb begin
    fault   = 1'b0;
    descend = 1'b0;
    size    = PG_SECTION;
    case (top_type_e'(type_bits))
      TOP_TABLE:   descend = 1'b1;
      TOP_SECTION: size = super_flag ? PG_SUPER : PG_SECTION;
      default:     fault = 1'b1;
    endcase
  end
endmodule

// File: rtl/tw_low_decode.sv
`timescale 1ns/1ps
module tw_low_decode
  import tlb_walker_pkg::*;
(
  input  logic [1:0] type_bits,
  output logic       fault,
  output pg_size_e   size
);
  always_comb begin
    fault = 1'b0;
    size  = PG_SECTION;
    case (low_type_e'(type_bits))
      LOW_LARGE: size = PG_LARGE;
      LOW_SMALL: size = PG_SMALL;
      default:   fault = 1'b1;
    endcase
  end
endmodule

// File: rtl/tlb_walker.sv
`timescale 1ns/1ps
module tlb_walker
  import tlb_walker_pkg::*;
#(
  parameter int L1_IDX_W = 12,
  parameter int L2_IDX_W = 8,
  parameter int PAGE_SH  = 12,
  parameter int LARGE_SH = 16,
  parameter int SUPER_SH = 24,
  parameter int SUPER_BIT = 18
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  input  logic [31:0] table_base,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        walk_done,
  output logic        walk_fault,
  output logic [1:0]  walk_size,
  output logic [31:0] walk_pa
);
  localparam int SECT_SH    = PAGE_SH + L2_IDX_W;
  localparam int VA_W       = SECT_SH + L1_IDX_W;
  localparam int TOP_TBL_SH = L1_IDX_W + 2;
  localparam int LOW_TBL_SH = L2_IDX_W + 2;
  localparam int N_SIZES    = 4;
  localparam int SIZE_SH [N_SIZES] = '{SECT_SH, LARGE_SH, PAGE_SH, SUPER_SH};

  walk_st_e        st;
  logic [VA_W-1:0] va_q, ptr_q;
  logic [VA_W-1:0] top_addr, low_addr;
  logic            res_fault;
  pg_size_e        res_size;
  logic [VA_W-1:0] res_pa;

  logic            top_fault, top_descend, low_fault;
  pg_size_e        top_size, low_size;
  logic [VA_W-1:0] cand [N_SIZES];

  tw_fetch_addr #(
    .VA_W(VA_W), .TOP_TBL_SH(TOP_TBL_SH), .LOW_TBL_SH(LOW_TBL_SH),
    .SECT_SH(SECT_SH), .PAGE_SH(PAGE_SH)
  ) u_addr (
    .table_base (table_base),
    .ptr_desc   (ptr_q),
    .va         (va_q),
    .top_addr   (top_addr),
    .low_addr   (low_addr)
  );

  tw_top_decode u_top (
    .type_bits  (mem_rsp_data[1:0]),
    .super_flag (mem_rsp_data[SUPER_BIT]),
    .fault      (top_fault),
    .descend    (top_descend),
    .size       (top_size)
  );

  tw_low_decode u_low (
    .type_bits (mem_rsp_data[1:0]),
    .fault     (low_fault),
    .size      (low_size)
  );

  // One merged address per page size: descriptor base above the split, VA offset below it.
  for (genvar g = 0; g < N_SIZES; g++) begin : g_merge
    localparam logic [VA_W-1:0] OFS_MASK = (VA_W'(1) << SIZE_SH[g]) - VA_W'(1);
    assign cand[g] = (mem_rsp_data & ~OFS_MASK) | (va_q & OFS_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      va_q      <= '0;
      ptr_q     <= '0;
      res_fault <= 1'b0;
      res_size  <= PG_SECTION;
      res_pa    <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          va_q <= req_va;
          st   <= ST_TOP_REQ;
        end
        ST_TOP_REQ:  if (mem_req_ready) st <= ST_TOP_WAIT;
        ST_TOP_WAIT: if (mem_rsp_valid) begin
          if (top_fault) begin
            res_fault <= 1'b1;
            res_size  <= PG_SECTION;
            res_pa    <= '0;
            st        <= ST_DONE;
          end else if (top_descend) begin
            ptr_q <= mem_rsp_data;
            st    <= ST_LOW_REQ;
          end else begin
            res_fault <= 1'b0;
            res_size  <= top_size;
            res_pa    <= cand[top_size];
            st        <= ST_DONE;
          end
        end
        ST_LOW_REQ:  if (mem_req_ready) st <= ST_LOW_WAIT;
        ST_LOW_WAIT: if (mem_rsp_valid) begin
          res_fault <= low_fault;
          res_size  <= low_fault ? PG_SECTION : low_size;
          res_pa    <= low_fault ? '0 : cand[low_size];
          st        <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready     = (st == ST_IDLE);
    mem_req_valid = (st == ST_TOP_REQ) || (st == ST_LOW_REQ);
    mem_addr      = (st == ST_LOW_REQ) ? low_addr : top_addr;
    walk_done     = (st == ST_DONE);
    walk_fault    = res_fault;
    walk_size     = res_size;
    walk_pa       = res_pa;
  end
endmodule

// File: rtl/tlb_walker_chk.sv
`timescale 1ns/1ps
module tlb_walker_chk #(
  parameter int VA_W       = 32,
  parameter int TOP_TBL_SH = 14,
  parameter int LOW_TBL_SH = 10,
  parameter int SECT_SH    = 20,
  parameter int PAGE_SH    = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_va,
  input logic [VA_W-1:0] table_base,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [VA_W-1:0] mem_addr,
  input logic            mem_rsp_valid,
  input logic [VA_W-1:0] mem_rsp_data,
  input logic            walk_done,
  input logic            walk_fault,
  input logic [1:0]      walk_size,
  input logic [VA_W-1:0] walk_pa
);
  localparam logic [VA_W-1:0] TOP_MASK = ~((VA_W'(1) << TOP_TBL_SH) - VA_W'(1));
  localparam logic [VA_W-1:0] LOW_MASK = ~((VA_W'(1) << LOW_TBL_SH) - VA_W'(1));

  logic [VA_W-1:0] va_c, first_rsp;
  logic [1:0]      n_fetch, n_rsp;
  logic [VA_W-1:0] exp_top, exp_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_c <= '0; first_rsp <= '0; n_fetch <= '0; n_rsp <= '0;
    end else if (req_valid && req_ready) begin
      va_c <= req_va; n_fetch <= '0; n_rsp <= '0;
    end else begin
      if (mem_req_valid && mem_req_ready) n_fetch <= n_fetch + 2'd1;
      if (mem_rsp_valid) begin
        n_rsp <= n_rsp + 2'd1;
        if (n_rsp == 2'd0) first_rsp <= mem_rsp_data;
      end
    end
  end

  assign exp_top = (table_base & TOP_MASK) | (VA_W'(va_c[VA_W-1:SECT_SH]) << 2);
  assign exp_low = (first_rsp & LOW_MASK) | (VA_W'(va_c[SECT_SH-1:PAGE_SH]) << 2);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> !walk_done);
  // R10
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));
  // R2
  top_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && n_fetch == 2'd0) |-> (mem_addr == exp_top));
  // R6
  low_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && n_fetch == 2'd1) |-> (mem_addr == exp_low));
  // R3
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done && walk_fault) |-> (walk_pa == '0 && walk_size == 2'd0));
  // R4
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done && !walk_fault && (walk_size == 2'd0 || walk_size == 2'd3)) |-> (n_fetch == 2'd1));
  // R7
  two_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done && !walk_fault && (walk_size == 2'd1 || walk_size == 2'd2)) |-> (n_fetch == 2'd2));
endmodule

bind tlb_walker tlb_walker_chk #(
  .VA_W(VA_W), .TOP_TBL_SH(TOP_TBL_SH), .LOW_TBL_SH(LOW_TBL_SH),
  .SECT_SH(SECT_SH), .PAGE_SH(PAGE_SH)
) u_chk (.*);

// File: tb/test_tlb_walker.sv
`timescale 1ns/1ps
module test_tlb_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [31:0] table_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        walk_done;
  logic        walk_fault;
  logic [1:0]  walk_size;
  logic [31:0] walk_pa;

  int n_chk = 0;
  int n_err = 0;
  int fetch_cnt = 0;
  int bad_addr = 0;
  logic [31:0] cur_l1, cur_l2;

  always #2.5 clk = ~clk;

  tlb_walker i_tlb_walker (.*);

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] va, l1d, l2d,
                                output logic [31:0] pa, output logic [1:0] sz,
                                output logic f, output int nf, output string tag);
    pa = '0; sz = 2'd0; f = 1'b0; nf = 1;
    case (l1d[1:0])
      2'b10: begin
        if (l1d[18]) begin pa = {l1d[31:24], va[23:0]}; sz = 2'd3; tag = "R5"; end
        else begin pa = {l1d[31:20], va[19:0]}; tag = "R4"; end
      end
      2'b01: begin
        nf = 2;
        case (l2d[1:0])
          2'b01: begin pa = {l2d[31:16], va[15:0]}; sz = 2'd1; tag = "R7"; end
          2'b10: begin pa = {l2d[31:12], va[11:0]}; sz = 2'd2; tag = "R8"; end
          default: begin f = 1'b1; tag = "R9"; end
        endcase
      end
      default: begin f = 1'b1; tag = "R3"; end
    endcase
  endfunction

  // Memory model: random acceptance and response delay; answers only the two expected addresses.
  initial begin
    logic hs_prev = 1'b0, v_prev = 1'b0, pend = 1'b0;
    logic [31:0] a_prev = '0, a_pend = '0;
    int lat = 0;
    int idx = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (rst_n) begin
        if (v_prev && !hs_prev) begin
          chk("R11 hold valid", {31'd0, mem_req_valid}, 32'd1);
          chk("R11 hold addr", mem_addr, a_prev);
        end
        if (hs_prev) begin
          pend = 1'b1; a_pend = a_prev; lat = $urandom % 3; idx = fetch_cnt; fetch_cnt++;
        end
        if (pend) begin
          if (lat == 0) begin
            logic [31:0] e1, e2;
            e1 = {table_base[31:14], req_va[31:20], 2'b00};
            e2 = {cur_l1[31:10], req_va[19:12], 2'b00};
            mem_rsp_valid = 1'b1;
            if (idx == 0 && a_pend == e1) mem_rsp_data = cur_l1;
            else if (idx == 1 && a_pend == e2) mem_rsp_data = cur_l2;
            else begin mem_rsp_data = 32'h3; bad_addr++; end
            pend = 1'b0;
          end else lat--;
        end
        mem_req_ready = ($urandom % 3) != 0;
        v_prev = mem_req_valid;
        hs_prev = mem_req_valid && mem_req_ready;
        a_prev = mem_addr;
      end
    end
  end

  task automatic walk(input logic [31:0] va, base, l1d, l2d);
    logic [31:0] epa; logic [1:0] esz; logic ef; int enf; string tag;
    int t;
    model(va, l1d, l2d, epa, esz, ef, enf, tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_l1 = l1d; cur_l2 = l2d; fetch_cnt = 0; bad_addr = 0;
    req_va = va; table_base = base; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 busy", {31'd0, req_ready}, 32'd0);
    t = 0;
    while (!walk_done && t < 200) begin @(negedge clk); t++; end
    chk({tag, " done"}, {31'd0, walk_done}, 32'd1);
    chk({tag, " pa"}, walk_pa, epa);
    chk({tag, " size"}, {30'd0, walk_size}, {30'd0, esz});
    chk({tag, " fault"}, {31'd0, walk_fault}, {31'd0, ef});
    chk({tag, " reads"}, fetch_cnt, enf);
    chk("R2/R6 fetch address", bad_addr, 0);
    @(negedge clk);
    chk("R10 pulse", {31'd0, walk_done}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk("R1 ready", {31'd0, req_ready}, 32'd1);
    chk("R1 memreq", {31'd0, mem_req_valid}, 32'd0);
    chk("R1 done", {31'd0, walk_done}, 32'd0);
    rst_n = 1'b1;
    // directed corners
    walk(32'h1234_5678, 32'h8000_3FFF, 32'hABC0_0002, 32'h0);            // R4 section, R2 low base bits ignored
    walk(32'hFFFF_FFFF, 32'h0000_0000, 32'h5A04_0002, 32'h0);            // R5 supersection
    walk(32'h0000_0000, 32'h4000_0000, 32'h0000_0000, 32'h0);            // R3 type 00
    walk(32'h8765_4321, 32'h4000_0000, 32'hFFFF_FFFF, 32'h0);            // R3 type 11
    walk(32'h9012_3456, 32'h1234_4000, 32'h7700_13FD, 32'hCAFE_0001);    // R6 pointer low bits ignored, R7 large
    walk(32'h9012_3FFF, 32'h1234_4000, 32'h7700_1001, 32'hBEEF_5FFE);    // R8 small
    walk(32'h3333_3333, 32'h0, 32'h2222_2001, 32'h1234_5670);            // R9 type 00
    walk(32'h3333_3333, 32'h0, 32'h2222_2001, 32'h1234_567F);            // R9 type 11
    // random mix
    for (int i = 0; i < 80; i++) begin
      logic [31:0] d1 = $urandom;
      case ($urandom % 5)
        0: d1[1:0] = 2'b10;
        1, 2: d1[1:0] = 2'b01;
        default: ;
      endcase
      walk($urandom, $urandom, d1, $urandom);
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule